// File: doc/BRIEF.md
# Half-Word Arithmetic Shifter with Half Merge

This combinational unit takes one 16-bit half of a 32-bit source word and shifts it by a signed amount. The direction follows the sign of the amount. A negative amount shifts right and copies the sign bit into the vacated positions. A positive amount shifts left and fills with zeros. The shifted half-word is then written into one half of a 32-bit destination word, and the other half keeps its previous contents.

The amount is taken from the low bits of a separate count word. A register-file write path uses the block as follows: it presents the source register, the count register and the current value of the destination register, and then writes back the merged word. Two selects choose the source half and the destination half. A small control stage turns the selects and the count into strobes, and a datapath stage performs the shift and the merge.

Top module: `half_ashift_unit`

## Requirements
- R1: When the 6-bit count (bits 5:0 of `countWord`, two's complement) is negative, the source half is shifted right by the magnitude of the count. The vacated upper bits are filled with copies of the source half's bit 15.
- R2: Right shifts truncate toward minus infinity and never round. With a count of -1: 0x8001 gives 0xC000, 0x8003 gives 0xC001, and 0x8005 gives 0xC002.
- R3: A count of zero writes the source half unchanged.
- R4: A right shift by a magnitude of 16 to 32 gives 0xFFFF when the source half is negative and 0x0000 otherwise. A count of -15 applied to a negative half-word also gives 0xFFFF.
- R5: A positive count from 1 to 15 shifts the source half left. It fills with zeros, drops the bits that pass bit 15, and does not saturate.
- R6: A positive count from 16 to 31 gives 0x0000.
- R7: `srcHiSel` = 1 takes the source half from bits 31:16 of `srcWord`, and 0 takes it from bits 15:0.
- R8: `dstHiSel` = 1 writes the result to bits 31:16 of `dstNew`, and 0 writes it to bits 15:0. The other half of `dstNew` equals the same half of `dstOld`.
- R9: Bits 31:6 of `countWord` have no effect on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| srcWord | input | 32 | Word that holds the half-word to be shifted |
| srcHiSel | input | 1 | 1 selects the upper source half, 0 the lower |
| countWord | input | 32 | Word whose bits 5:0 hold the signed shift amount |
| dstOld | input | 32 | Current value of the destination word |
| dstHiSel | input | 1 | 1 writes the result to the upper half, 0 to the lower |
| dstNew | output | 32 | Destination word with the shifted half merged in |

## Verification
The checker evaluates several rules on every input change:
- The unwritten half of the destination always matches the old destination.
- A zero count passes the source half through.
- Right shifts keep the sign bit.
- Left shifts leave bit 0 clear.
- Large right amounts flush the result to the sign, and large left amounts flush it to zero.

Other behaviour needs the bench's scenarios. Exact bit values, truncation rather than rounding, the choice between the source halves, and the fact that the upper count bits are ignored are all shown there. The bench also sweeps every count from -32 to 31 with every select combination against an arithmetic-shift reference.

// File: rtl/half_ashift_pkg.sv
package half_ashift_pkg;
  localparam int HALF_W_DEF = 16;
  localparam int CNT_W_DEF  = 6;

  // strobes from the control stage to the datapath stage
  typedef struct packed {
    logic                 srcHi;   // pick upper source half
    logic                 dstHi;   // write upper destination half
    logic                 goRight; // arithmetic right shift
    logic                 flush;   // magnitude reaches the half width
    logic [CNT_W_DEF-1:0] amt;     // shift magnitude
  } shift_ctrl_t;
endpackage

// File: rtl/half_ashift_ctrl.sv
module half_ashift_ctrl
  import half_ashift_pkg::*;
#(
  parameter int HALF_W = HALF_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic              srcHiSel,
  input  logic              dstHiSel,
  input  logic [WORD_W-1:0] countWord,
  output shift_ctrl_t       ctrl
);
  logic [CNT_W-1:0] cntField;
  logic [CNT_W-1:0] magnitude;
  logic             isNeg;
  logic             unusedCountBits;

  assign cntField        = countWord[CNT_W-1:0];
  assign unusedCountBits = ^countWord[WORD_W-1:CNT_W];
  assign isNeg           = cntField[CNT_W-1];
  // -32 maps to an unsigned magnitude of 32, which still fits
  assign magnitude       = isNeg ? (~cntField + 1'b1) : cntField;

  always_comb begin
    ctrl         = '0;
    ctrl.srcHi   = srcHiSel;
    ctrl.dstHi   = dstHiSel;
    ctrl.goRight = isNeg;
    ctrl.flush   = (32'(magnitude) >= HALF_W);
    ctrl.amt     = magnitude;
  end
endmodule

// File: rtl/half_ashift_dp.sv
module half_ashift_dp
  import half_ashift_pkg::*;
#(
  parameter int HALF_W = HALF_W_DEF,
  localparam int WORD_W = 2 * HALF_W,
  localparam int NHALF  = 2
) (
  input  shift_ctrl_t       ctrl,
  input  logic [WORD_W-1:0] srcWord,
  input  logic [WORD_W-1:0] dstOld,
  output logic [WORD_W-1:0] dstNew
);
  logic [HALF_W-1:0] srcHalf;
  logic [HALF_W-1:0] shifted;
  logic              signBit;

  assign srcHalf = ctrl.srcHi ? srcWord[WORD_W-1:HALF_W] : srcWord[HALF_W-1:0];
  assign signBit = srcHalf[HALF_W-1];

  always_comb begin
    if (ctrl.flush)
      shifted = ctrl.goRight ? {HALF_W{signBit}} : '0;
    else if (ctrl.goRight)
      shifted = HALF_W'($signed(srcHalf) >>> ctrl.amt);
    else
      shifted = srcHalf << ctrl.amt;
  end

  // one lane per destination half: take the result or keep the old contents
  for (genvar h = 0; h < NHALF; h++) begin : g_lane
    localparam logic LANE_HI = (h == 1);
    assign dstNew[h*HALF_W +: HALF_W] =
      (ctrl.dstHi == LANE_HI) ? shifted : dstOld[h*HALF_W +: HALF_W];
  end
endmodule

// File: rtl/half_ashift_unit.sv
module half_ashift_unit
  import half_ashift_pkg::*;
#(
  parameter int HALF_W = HALF_W_DEF,
  parameter int CNT_W  = CNT_W_DEF,
  localparam int WORD_W = 2 * HALF_W
) (
  input  logic [WORD_W-1:0] srcWord,
  input  logic              srcHiSel,
  input  logic [WORD_W-1:0] countWord,
  input  logic [WORD_W-1:0] dstOld,
  input  logic              dstHiSel,
  output logic [WORD_W-1:0] dstNew
);
  shift_ctrl_t ctrl;

  half_ashift_ctrl #(.HALF_W(HALF_W), .CNT_W(CNT_W)) ctrl_i (
    .srcHiSel (srcHiSel),
    .dstHiSel (dstHiSel),
    .countWord(countWord),
    .ctrl     (ctrl)
  );

  half_ashift_dp #(.HALF_W(HALF_W)) dp_i (
    .ctrl   (ctrl),
    .srcWord(srcWord),
    .dstOld (dstOld),
    .dstNew (dstNew)
  );
endmodule

// File: rtl/half_ashift_checker.sv
module half_ashift_checker #(
  parameter int HALF_W = 16,
  parameter int CNT_W  = 6,
  localparam int WORD_W = 2 * HALF_W
) (
  input logic [WORD_W-1:0] srcWord,
  input logic              srcHiSel,
  input logic [WORD_W-1:0] countWord,
  input logic [WORD_W-1:0] dstOld,
  input logic              dstHiSel,
  input logic [WORD_W-1:0] dstNew
);
  logic signed [CNT_W-1:0] cnt;
  logic [HALF_W-1:0] inHalf;
  logic [HALF_W-1:0] outHalf;
  logic [HALF_W-1:0] keptOut;
  logic [HALF_W-1:0] keptOld;

  assign cnt     = countWord[CNT_W-1:0];
  assign inHalf  = srcHiSel ? srcWord[WORD_W-1:HALF_W] : srcWord[HALF_W-1:0];
  assign outHalf = dstHiSel ? dstNew[WORD_W-1:HALF_W] : dstNew[HALF_W-1:0];
  assign keptOut = dstHiSel ? dstNew[HALF_W-1:0] : dstNew[WORD_W-1:HALF_W];
  assign keptOld = dstHiSel ? dstOld[HALF_W-1:0] : dstOld[WORD_W-1:HALF_W];

  always_comb begin
    p_keep_other_half_r8: assert (keptOut == keptOld);
    if (cnt == 0)
      p_zero_pass_r3: assert (outHalf == inHalf);
    if (cnt < 0)
      p_right_keeps_sign_r1: assert (outHalf[HALF_W-1] == inHalf[HALF_W-1]);
    if (int'(cnt) <= -HALF_W)
      p_right_flush_r4: assert (outHalf == {HALF_W{inHalf[HALF_W-1]}});
    if (cnt > 0)
      p_left_zero_fill_r5: assert (outHalf[0] == 1'b0);
    if (int'(cnt) >= HALF_W)
      p_left_flush_r6: assert (outHalf == '0);
  end
endmodule

bind half_ashift_unit half_ashift_checker #(.HALF_W(HALF_W), .CNT_W(CNT_W)) chk_i (
  .srcWord  (srcWord),
  .srcHiSel (srcHiSel),
  .countWord(countWord),
  .dstOld   (dstOld),
  .dstHiSel (dstHiSel),
  .dstNew   (dstNew)
);

// File: tb/half_ashift_unit_tb.sv
module half_ashift_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] srcWord = '0;
  logic        srcHiSel = 1'b0;
  logic [31:0] countWord = '0;
  logic [31:0] dstOld = '0;
  logic        dstHiSel = 1'b0;
  logic [31:0] dstNew;

  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  half_ashift_unit dut_i (
    .srcWord(srcWord), .srcHiSel(srcHiSel), .countWord(countWord),
    .dstOld(dstOld), .dstHiSel(dstHiSel), .dstNew(dstNew)
  );

  // vector: src, srcHi, count, dstOld, dstHi, expected
  localparam int NV = 18;
  localparam logic [129:0] VEC [NV] = '{
    {32'h00008001, 1'b0, 32'h0000FFFF, 32'h00008001, 1'b0, 32'h0000C000}, // R2
    {32'h00008003, 1'b0, 32'h0000FFFF, 32'h00008003, 1'b0, 32'h0000C001}, // R2
    {32'h00008005, 1'b0, 32'h0000FFFF, 32'h00008005, 1'b0, 32'h0000C002}, // R2
    {32'h80010000, 1'b1, 32'h00000000, 32'h80010000, 1'b0, 32'h80018001}, // R3 R7
    {32'h80010000, 1'b1, 32'h0000FFFF, 32'h80010000, 1'b0, 32'h8001C000}, // R8
    {32'hA0010000, 1'b1, 32'h0000FFF1, 32'hA0010000, 1'b0, 32'hA001FFFF}, // R4 -15
    {32'h00009001, 1'b0, 32'h0000FFF0, 32'h00009001, 1'b1, 32'hFFFF9001}, // R4 R8
    {32'h00008001, 1'b0, 32'h0000FFFF, 32'h00008001, 1'b1, 32'hC0008001}, // R8
    {32'h00004000, 1'b0, 32'h0000003F, 32'h00000000, 1'b0, 32'h00002000}, // R1
    {32'h00000001, 1'b0, 32'h0000000F, 32'h00000000, 1'b0, 32'h00008000}, // R5
    {32'h00000003, 1'b0, 32'h00000001, 32'h12340000, 1'b0, 32'h12340006}, // R5
    {32'h0000C001, 1'b0, 32'h00000002, 32'h00000000, 1'b0, 32'h00000004}, // R5
    {32'h00007FFF, 1'b0, 32'h00000010, 32'hFFFFFFFF, 1'b0, 32'hFFFF0000}, // R6
    {32'h0000FFFF, 1'b0, 32'h0000001F, 32'h00000000, 1'b0, 32'h00000000}, // R6
    {32'h00008000, 1'b0, 32'h00000020, 32'h00000000, 1'b0, 32'h0000FFFF}, // R4 -32
    {32'h00004000, 1'b0, 32'h00000020, 32'hAAAA0000, 1'b0, 32'hAAAA0000}, // R4 -32
    {32'h00000001, 1'b0, 32'hFFFFFFC1, 32'h00000000, 1'b0, 32'h00000002}, // R9
    {32'h00001234, 1'b0, 32'h00000040, 32'h00000000, 1'b0, 32'h00001234}  // R9
  };

  task automatic check(input string req, input logic [31:0] exp);
    testsRun++;
    if (dstNew !== exp) begin
      testsFailed++;
      $display("FAIL %s: got %08h expected %08h (src=%08h sh=%0b cnt=%08h old=%08h dh=%0b)",
               req, dstNew, exp, srcWord, srcHiSel, countWord, dstOld, dstHiSel);
    end
  endtask

  task automatic apply(input logic [31:0] s, input logic sh, input logic [31:0] c,
                       input logic [31:0] o, input logic dh);
    @(posedge clk);
    srcWord = s; srcHiSel = sh; countWord = c; dstOld = o; dstHiSel = dh;
    @(negedge clk);
  endtask

  // reference built on the integer arithmetic shift
  function automatic logic [31:0] refModel(input logic [31:0] s, input logic sh,
                                           input logic [31:0] c, input logic [31:0] o,
                                           input logic dh);
    logic [15:0] h;
    int sv;
    int n;
    logic [15:0] r;
    logic [31:0] w;
    h  = sh ? s[31:16] : s[15:0];
    sv = int'($signed(h));
    n  = int'($signed(c[5:0]));
    if (n < 0) r = 16'(sv >>> (-n));
    else if (n >= 16) r = 16'h0000;
    else r = 16'(sv << n);
    w = o;
    if (dh) w[31:16] = r; else w[15:0] = r;
    return w;
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R3 reset-state zero inputs", 32'h0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i][129:98], VEC[i][97], VEC[i][96:65], VEC[i][64:33], VEC[i][32]);
      check($sformatf("R1-set vector %0d (R2 R3 R4 R5 R6 R7 R8 R9)", i), VEC[i][31:0]);
    end

    // exhaustive count sweep against the reference (R1 R4 R5 R6 R7 R8)
    for (int p = 0; p < 4; p++) begin
      logic [31:0] pat;
      case (p)
        0: pat = 32'h8001_7FFE;
        1: pat = 32'h1234_F00D;
        2: pat = 32'hFFFF_0001;
        default: pat = 32'h5A5A_A5A5;
      endcase
      for (int sh = 0; sh < 2; sh++) begin
        for (int dh = 0; dh < 2; dh++) begin
          for (int c = -32; c < 32; c++) begin
            logic [31:0] cw;
            logic [31:0] ov;
            cw = {26'h2AAAAAA ^ 26'(p), 6'(c)}; // R9 junk above bit 5
            ov = ~pat;
            apply(pat, sh[0], cw, ov, dh[0]);
            check("R1 R4 R5 R6 R7 R8 R9 sweep", refModel(pat, sh[0], cw, ov, dh[0]));
          end
        end
      end
    end

    if (!finished) begin
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!finished) begin
      finished = 1'b1;
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end
endmodule